// File: doc/BRIEF.md
# Prescaled 16-bit Event Counter with Tear-Free Byte Reads

The block is a 16-bit up-counter that software reaches through a small 8-bit register bus. Each increment is gated by a count-enable pulse. A 3-bit source field chooses where that pulse comes from:

- a divide-by-12 prescaler on the system clock;
- a divide-by-4 prescaler on the system clock;
- an overflow pulse from a neighbouring timer;
- falling edges on an external pin;
- every system clock;
- one pulse per eight rising edges of a slow external oscillator.

The pin and the oscillator are resynchronized into the system clock domain before use. Every source gives single-cycle enable pulses, and the counter never runs on a second clock.

Software reads the count as two bytes. Reading the low byte captures the high byte into a shadow register. The high-byte read that follows returns that shadow, so a low-then-high read pair always forms a consistent 16-bit value, even if the counter carried between the two reads. Byte writes load the counter directly.

A control register holds the run bit, a sticky wrap flag, the local interrupt enable, an idle-freeze bit and the source field. The interrupt request is raised when all of the following are 1: the flag, the local enable, the module-level enable input and the chip-wide enable input.

Top module: `tick_counter16`

## Requirements
- R1: After reset the count, the shadow byte and every control field are 0, and `irq_o` is 0.
- R2: Register addresses are: 0 = count low byte, 1 = high byte as shadow, 2 = control, 3 = reads 0. The control byte layout is: bit0 run, bit1 wrap flag, bit2 local interrupt enable, bit3 idle freeze, bits6:4 source, bit7 reads 0. Read data is the combinational value of the addressed register in the same cycle.
- R3: With source 100 and run at 1, the count rises by one on every clock.
- R4: With source 000 the count advances once per 12 clocks, and with source 001 once per 4 clocks. Both prescalers run freely from reset and pulse when they reach their last value (11 and 3).
- R5: With source 010 the count advances on every clock in which `aux_tick_i` is 1.
- R6: With source 011 each high-to-low change of `ext_pin_i` advances the count once, and rising changes do not. The pin passes through two synchronizer flops. A pin value sampled at clock edge k produces its increment at edge k+2. The pin must stay at each level for at least 4 clocks.
- R7: With source 101 the count advances once per eight synchronized rising edges of `ext_osc_i`. The eighth-edge counter starts at 0 from reset, and each increment lands two edges after the sampling edge, as for the pin.
- R8: Source codes 110 and 111 produce no increments, whatever the other inputs do.
- R9: Reading address 0 copies the present high byte into the shadow. Reading address 1 returns the shadow, not the live high byte. Reads never change the count.
- R10: A write to address 0 or 1 replaces that byte of the count. No increment happens in the cycle of such a write.
- R11: An increment from 0xFFFF to 0x0000 sets the wrap flag. The flag stays set until a control write with bit1 = 0. A control write with bit1 = 1 leaves it unchanged, and a wrap in the same cycle as a clearing write leaves it set.
- R12: `irq_o` is 1 exactly when the wrap flag, control bit2, `mod_irq_en_i` and `glb_irq_en_i` are all 1.
- R13: With control bit3 at 1 the count holds while `idle_i` is 1. With bit3 at 0 the `idle_i` input has no effect.
- R14: With the run bit at 0 the count holds, except for byte writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_rd | input | 1 | Read strobe (arms the shadow on address 0) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| aux_tick_i | input | 1 | Overflow pulse from a neighbouring timer |
| ext_pin_i | input | 1 | External event pin, asynchronous |
| ext_osc_i | input | 1 | Slow external oscillator, asynchronous |
| idle_i | input | 1 | Idle indication |
| mod_irq_en_i | input | 1 | Module-level interrupt enable |
| glb_irq_en_i | input | 1 | Chip-wide interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Results are due at different times after a stimulus:

- Read data and `irq_o` depend only on state, so they are due in the same cycle as the address or as the flag update.
- The count, the flag, the shadow and the control fields change at the first clock edge after the strobe or tick.
- Pin falling edges and oscillator rising edges reach the count two edges after the edge that samples them.

The bench drives inputs just after the falling clock edge and compares outputs one nanosecond later, well before the next rising edge. It advances its reference model only at rising edges from the inputs present at that edge, so every compare sees exactly the state the design holds at that point.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SRC_DIV_SLOW = 3'b000,
    SRC_DIV_FAST = 3'b001,
    SRC_AUX      = 3'b010,
    SRC_PIN_FALL = 3'b011,
    SRC_SYSCLK   = 3'b100,
    SRC_OSC_DIV  = 3'b101
  } src_sel_e;

  localparam logic [1:0] ADDR_LO  = 2'd0;
  localparam logic [1:0] ADDR_HI  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
endpackage

// File: rtl/tc_divider.sv
module tc_divider #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R4
      div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tc_sync_edge.sv
module tc_sync_edge #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      hist_q <= sync_q[STAGES-1];
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = hist_q && !sync_q[STAGES-1];
    end else begin : g_rise
      assign edge_o = !hist_q && sync_q[STAGES-1];
    end
  endgenerate

  // R6
  edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/tc_tick_mux.sv
module tc_tick_mux
  import tc_pkg::*;
(
  input  logic [2:0] sel_i,
  input  logic       slow_i,
  input  logic       fast_i,
  input  logic       aux_i,
  input  logic       pin_i,
  input  logic       osc_i,
  output logic       tick_o
);
  always_comb begin
    case (src_sel_e'(sel_i))
      SRC_DIV_SLOW: tick_o = slow_i;
      SRC_DIV_FAST: tick_o = fast_i;
      SRC_AUX:      tick_o = aux_i;
      SRC_PIN_FALL: tick_o = pin_i;
      SRC_SYSCLK:   tick_o = 1'b1;
      SRC_OSC_DIV:  tick_o = osc_i;
      default:      tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tick_counter16.sv
module tick_counter16
  import tc_pkg::*;
#(
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 4,
  parameter int OSC_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              aux_tick_i,
  input  logic              ext_pin_i,
  input  logic              ext_osc_i,
  input  logic              idle_i,
  input  logic              mod_irq_en_i,
  input  logic              glb_irq_en_i,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic slow_tick, fast_tick, pin_fall, osc_rise, osc_tick, src_tick;

  tc_divider #(.DIV(SLOW_DIV)) u_slow (
    .clk(clk), .rst_n(rst_n), .en_i(1'b1), .tick_o(slow_tick));
  tc_divider #(.DIV(FAST_DIV)) u_fast (
    .clk(clk), .rst_n(rst_n), .en_i(1'b1), .tick_o(fast_tick));

  tc_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_pin (
    .clk(clk), .rst_n(rst_n), .async_i(ext_pin_i), .edge_o(pin_fall));
  tc_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_osc (
    .clk(clk), .rst_n(rst_n), .async_i(ext_osc_i), .edge_o(osc_rise));
  tc_divider #(.DIV(OSC_DIV)) u_oscdiv (
    .clk(clk), .rst_n(rst_n), .en_i(osc_rise), .tick_o(osc_tick));

  logic [2:0] sel_q, sel_d;

  tc_tick_mux u_mux (
    .sel_i(sel_q), .slow_i(slow_tick), .fast_i(fast_tick), .aux_i(aux_tick_i),
    .pin_i(pin_fall), .osc_i(osc_tick), .tick_o(src_tick));

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] snap_q, snap_d;
  logic run_q, run_d, flag_q, flag_d, ie_q, ie_d, frz_q, frz_d;
  logic wr_lo, wr_hi, wr_ctl, rd_lo, cnt_adv, wrap;

  assign wr_lo  = reg_wr && (reg_addr == ADDR_LO);
  assign wr_hi  = reg_wr && (reg_addr == ADDR_HI);
  assign wr_ctl = reg_wr && (reg_addr == ADDR_CTL);
  assign rd_lo  = reg_rd && (reg_addr == ADDR_LO);

  assign cnt_adv = run_q && !(frz_q && idle_i) && src_tick && !wr_lo && !wr_hi;
  assign wrap    = cnt_adv && (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d  = cnt_q;
    snap_d = snap_q;
    run_d  = run_q;
    ie_d   = ie_q;
    frz_d  = frz_q;
    sel_d  = sel_q;
    flag_d = flag_q;
    if (wr_lo)        cnt_d[BYTE_W-1:0]     = reg_wdata;
    else if (wr_hi)   cnt_d[CNT_W-1:BYTE_W] = reg_wdata;
    else if (cnt_adv) cnt_d                 = cnt_q + 1'b1;
    if (rd_lo) snap_d = cnt_q[CNT_W-1:BYTE_W];
    if (wr_ctl) begin
      run_d  = reg_wdata[0];
      flag_d = flag_q && reg_wdata[1];
      ie_d   = reg_wdata[2];
      frz_d  = reg_wdata[3];
      sel_d  = reg_wdata[6:4];
    end
    if (wrap) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      frz_q  <= 1'b0;
      sel_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      snap_q <= snap_d;
      run_q  <= run_d;
      flag_q <= flag_d;
      ie_q   <= ie_d;
      frz_q  <= frz_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_LO:  reg_rdata = cnt_q[BYTE_W-1:0];
      ADDR_HI:  reg_rdata = snap_q;
      ADDR_CTL: reg_rdata = {1'b0, sel_q, frz_q, ie_q, flag_q, run_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_o = flag_q && ie_q && mod_irq_en_i && glb_irq_en_i;

  // R11
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_adv && cnt_q == CNT_MAX) |=> (cnt_q == '0 && flag_q));
  // R11
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_ctl && !reg_wdata[1])) |=> flag_q);
  // R14
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_lo && !wr_hi) |=> $stable(cnt_q));
  // R9
  snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (snap_q == $past(cnt_q[CNT_W-1:BYTE_W])));
  // R10
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_q[BYTE_W-1:0] == $past(reg_wdata)));
endmodule

// File: tb/test_tick_counter16.sv
module test_tick_counter16;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_rd, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       aux, pin, osc, idle, mod_en, glb_en, irq;

  tick_counter16 i_tick_counter16 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .aux_tick_i(aux), .ext_pin_i(pin), .ext_osc_i(osc), .idle_i(idle),
    .mod_irq_en_i(mod_en), .glb_irq_en_i(glb_en), .irq_o(irq));

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // reference model state
  bit [15:0] m_cnt;
  bit [7:0]  m_snap;
  bit        m_run, m_flag, m_ie, m_frz;
  bit [2:0]  m_sel;
  int        p_slow, p_fast, p_osc;
  bit        pd1, pd2, pd3, od1, od2, od3;

  always @(posedge clk) begin : ref_model
    bit fall, rise, tk, en, wlo, whi, wct;
    if (!rst_n) begin
      m_cnt = 0; m_snap = 0; m_run = 0; m_flag = 0; m_ie = 0; m_frz = 0;
      m_sel = 0; p_slow = 0; p_fast = 0; p_osc = 0;
      pd1 = 0; pd2 = 0; pd3 = 0; od1 = 0; od2 = 0; od3 = 0;
    end else begin
      fall = pd3 && !pd2;
      rise = od2 && !od3;
      case (m_sel)
        3'd0: tk = (p_slow == 11);
        3'd1: tk = (p_fast == 3);
        3'd2: tk = aux;
        3'd3: tk = fall;
        3'd4: tk = 1'b1;
        3'd5: tk = rise && (p_osc == 7);
        default: tk = 1'b0;
      endcase
      wlo = reg_wr && reg_addr == 2'd0;
      whi = reg_wr && reg_addr == 2'd1;
      wct = reg_wr && reg_addr == 2'd2;
      en  = m_run && !(m_frz && idle) && tk && !wlo && !whi;
      if (reg_rd && reg_addr == 2'd0) m_snap = m_cnt[15:8];
      if (wct) m_flag = m_flag && reg_wdata[1];
      if (en && m_cnt == 16'hFFFF) m_flag = 1'b1;
      if (wlo)      m_cnt[7:0]  = reg_wdata;
      else if (whi) m_cnt[15:8] = reg_wdata;
      else if (en)  m_cnt       = m_cnt + 16'd1;
      if (wct) begin
        m_run = reg_wdata[0]; m_ie = reg_wdata[2];
        m_frz = reg_wdata[3]; m_sel = reg_wdata[6:4];
      end
      p_slow = (p_slow == 11) ? 0 : p_slow + 1;
      p_fast = (p_fast == 3) ? 0 : p_fast + 1;
      if (rise) p_osc = (p_osc == 7) ? 0 : p_osc + 1;
      pd3 = pd2; pd2 = pd1; pd1 = pin;
      od3 = od2; od2 = od1; od1 = osc;
    end
  end

  function automatic logic [7:0] exp_rdata();
    case (reg_addr)
      2'd0:    return m_cnt[7:0];
      2'd1:    return m_snap;
      2'd2:    return {1'b0, m_sel, m_frz, m_ie, m_flag, m_run};
      default: return 8'h00;
    endcase
  endfunction

  task automatic compare();
    logic [7:0] er;
    logic       ei;
    er = exp_rdata();
    ei = m_flag && m_ie && mod_en && glb_en;
    n_chk += 2;
    if (reg_rdata !== er) begin
      n_bad++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", cur_req, reg_addr, reg_rdata, er);
    end
    if (irq !== ei) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, ei);
    end
  endtask

  task automatic cyc(input logic [1:0] a, input logic rd, input logic wr, input logic [7:0] wd);
    @(negedge clk);
    reg_addr = a; reg_rd = rd; reg_wr = wr; reg_wdata = wd;
    #1;
    compare();
  endtask

  task automatic rd_lo(input int n);
    for (int i = 0; i < n; i++) cyc(2'd0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(a, 1'b0, 1'b1, d);
  endtask

  task automatic expect_val(input logic [7:0] v);
    n_chk++;
    if (reg_rdata !== v) begin
      n_bad++;
      $display("FAIL %s literal actual=%h expected=%h", cur_req, reg_rdata, v);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; reg_addr = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
    aux = 0; pin = 0; osc = 0; idle = 0; mod_en = 0; glb_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state on every register
    cur_req = "R1";
    cyc(2'd0, 1'b0, 1'b0, 8'h00); expect_val(8'h00);
    cyc(2'd1, 1'b0, 1'b0, 8'h00); expect_val(8'h00);
    cyc(2'd2, 1'b0, 1'b0, 8'h00); expect_val(8'h00);
    cur_req = "R2";
    cyc(2'd3, 1'b1, 1'b0, 8'h00); expect_val(8'h00);
    // R3 every clock
    cur_req = "R3";
    wr(2'd2, 8'h41);
    rd_lo(20);
    // R4 prescaled sources
    cur_req = "R4";
    wr(2'd2, 8'h01);
    rd_lo(40);
    wr(2'd2, 8'h11);
    rd_lo(20);
    // R5 auxiliary pulse
    cur_req = "R5";
    wr(2'd2, 8'h21);
    for (int i = 0; i < 24; i++) begin
      aux = (i % 3 != 0);
      rd_lo(1);
    end
    aux = 0;
    // R6 falling edges on the pin
    cur_req = "R6";
    wr(2'd2, 8'h31);
    for (int i = 0; i < 10; i++) begin
      pin = ~pin;
      rd_lo(5);
    end
    pin = 0;
    rd_lo(4);
    // R7 oscillator divided by 8
    cur_req = "R7";
    wr(2'd2, 8'h51);
    for (int i = 0; i < 60; i++) begin
      osc = ~osc;
      rd_lo(2);
    end
    // R8 reserved codes
    cur_req = "R8";
    wr(2'd2, 8'h61);
    for (int i = 0; i < 12; i++) begin
      aux = 1; pin = ~pin; osc = ~osc;
      rd_lo(2);
    end
    wr(2'd2, 8'h71);
    for (int i = 0; i < 12; i++) begin
      pin = ~pin; osc = ~osc;
      rd_lo(2);
    end
    aux = 0;
    // R10 byte loads, R9 shadow read
    cur_req = "R10";
    wr(2'd2, 8'h40);
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'h12);
    cyc(2'd0, 1'b0, 1'b0, 8'h00); expect_val(8'hFE);
    cur_req = "R9";
    wr(2'd2, 8'h41);
    rd_lo(1);
    cyc(2'd2, 1'b0, 1'b0, 8'h00);
    cyc(2'd1, 1'b1, 1'b0, 8'h00); expect_val(8'h12);
    cyc(2'd0, 1'b1, 1'b0, 8'h00);
    cyc(2'd1, 1'b1, 1'b0, 8'h00); expect_val(8'h13);
    cur_req = "R10";
    wr(2'd0, 8'h55);
    cyc(2'd0, 1'b0, 1'b0, 8'h00);
    rd_lo(3);
    // R11 wrap flag, R12 interrupt gating
    cur_req = "R11";
    wr(2'd2, 8'h44);
    wr(2'd0, 8'hF8);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h45);
    rd_lo(12);
    cyc(2'd2, 1'b0, 1'b0, 8'h00);
    wr(2'd2, 8'h46);
    cyc(2'd2, 1'b0, 1'b0, 8'h00);
    cur_req = "R12";
    mod_en = 1; cyc(2'd2, 1'b0, 1'b0, 8'h00);
    glb_en = 1; cyc(2'd2, 1'b0, 1'b0, 8'h00);
    wr(2'd2, 8'h42); cyc(2'd2, 1'b0, 1'b0, 8'h00);
    wr(2'd2, 8'h46); mod_en = 0; cyc(2'd2, 1'b0, 1'b0, 8'h00);
    mod_en = 1; glb_en = 0; cyc(2'd2, 1'b0, 1'b0, 8'h00);
    glb_en = 1; cyc(2'd2, 1'b0, 1'b0, 8'h00);
    cur_req = "R11";
    wr(2'd2, 8'h44);
    cyc(2'd2, 1'b0, 1'b0, 8'h00);
    // clear in the same cycle as a wrap keeps the flag
    wr(2'd2, 8'h40);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h45);
    wr(2'd2, 8'h45);
    cyc(2'd2, 1'b0, 1'b0, 8'h00);
    wr(2'd2, 8'h44);
    cyc(2'd2, 1'b0, 1'b0, 8'h00);
    // R13 idle freeze
    cur_req = "R13";
    wr(2'd2, 8'h49);
    idle = 1; rd_lo(6);
    idle = 0; rd_lo(4);
    wr(2'd2, 8'h41);
    idle = 1; rd_lo(6);
    idle = 0;
    // R14 run bit off
    cur_req = "R14";
    wr(2'd2, 8'h40);
    rd_lo(8);
    wr(2'd2, 8'h41);
    rd_lo(3);
    finish_up();
  end
endmodule